// File: doc/BRIEF.md
# Sequenced Framing-Pulse Generator

This block produces groups of sequenced framing strobes that stay locked to the frame timing of a time-division telecom bus. Each group drives twelve active-high lines. Once per frame, the twelve lines pulse one after another. Each pulse is one of four programmable widths, and the first pulse begins at a programmable bit position counted from frame sync. The pulses in a group touch end to end, never overlap, and may run across the frame boundary into the next frame.

Two groups are built side by side. They share the bit clock and the frame sync input, but each group has its own enable, width mode and start offset. A group reads its width and offset only on a frame sync, so software may rewrite them at any time without breaking a sequence that is already running. Register access and the generation of the clock and sync are done outside this block.

Top module: `seq_frame_pulser`

## Requirements
- R1: While reset is asserted, and after reset until a group has started a sequence, every bit of `pulses` is low.
- R2: Frame bit time 0 is the clock cycle after the cycle in which `frameSync` is sampled high. Line 0 of an enabled group goes high in the cycle at bit time `startOffset`, for any offset from 0 to FRAME_BITS-1.
- R3: The width mode sets how many consecutive cycles each line stays high: 2'b00 gives 1 cycle, 2'b01 gives 2 cycles, 2'b10 gives 8 cycles and 2'b11 gives 16 cycles.
- R4: Line n goes high in the cycle right after line n-1 goes low. At most one line of a group is high in any cycle. The sequence ends when line 11 goes low.
- R5: A sequence that reaches the frame end carries on into the following frame without a gap.
- R6: Width mode and start offset are sampled only in a cycle where `frameSync` is high. A change between syncs has no effect until the next sync.
- R7: When a group's enable is low at a clock edge, all of its lines are low from the next cycle. After the enable rises again, the group starts no sequence until it has seen a frame sync.
- R8: Group g uses `widthMode[2g+1:2g]`, `startOffset[10g+9:10g]`, `groupEn[g]` and `pulses[12g+11:12g]`. The two groups do not affect each other.
- R9: If the start position is reached while a sequence is still running, the running sequence is dropped and line 0 begins again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | One-cycle frame sync strobe, shared by both groups |
| groupEn | input | 2 | Enable for each group |
| widthMode | input | 4 | Pulse width code, 2 bits per group |
| startOffset | input | 20 | Start bit position, 10 bits per group |
| pulses | output | 24 | Sequenced framing lines, 12 per group |

## Verification
The assertions assume that `frameSync` is a clean single-cycle strobe. They do not assume a fixed frame period, because the position counter wraps by itself if a sync is missing. The stimulus sends a sync exactly once every FRAME_BITS cycles. It changes width, offset and enable only on falling clock edges, and sometimes in the middle of a frame or in the middle of a sequence. Offsets are drawn from the full 10-bit range, including positions near the frame end, so that wrapping and restarting are both exercised.

// File: rtl/seq_frame_pkg.sv
package seq_frame_pkg;

  typedef enum logic [1:0] {
    WIDTH_ONE  = 2'b00,
    WIDTH_TWO  = 2'b01,
    WIDTH_BYTE = 2'b10,
    WIDTH_WORD = 2'b11
  } pulseWidth_e;

  localparam int WCNT_W = 4;

  // Strobes passed from the frame control to the sequencer datapath.
  typedef struct packed {
    logic        launch;
    logic        halt;
    pulseWidth_e width;
  } seqCmd_t;

  // Last value of the in-pulse cycle counter for a given width code.
  function automatic logic [WCNT_W-1:0] widthLast(pulseWidth_e w);
    case (w)
      WIDTH_ONE:  widthLast = 4'd0;
      WIDTH_TWO:  widthLast = 4'd1;
      WIDTH_BYTE: widthLast = 4'd7;
      default:    widthLast = 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/frame_pulse_ctrl.sv
module frame_pulse_ctrl
  import seq_frame_pkg::*;
#(
  parameter int FRAME_BITS = 1024,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSync,
  input  logic             groupEn,
  input  pulseWidth_e      modeIn,
  input  logic [POS_W-1:0] offsetIn,
  output seqCmd_t          cmdOut
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] posCnt;
  logic [POS_W-1:0] actOffset;
  pulseWidth_e      actMode;
  logic             synced;

  logic [POS_W-1:0] nextPos;
  logic [POS_W-1:0] nextOffset;
  pulseWidth_e      nextMode;
  logic             armed;

  // Decide one cycle ahead, so the datapath registers land on the bit time.
  always_comb begin
    if (frameSync)
      nextPos = '0;
    else if (posCnt == LAST_POS)
      nextPos = '0;
    else
      nextPos = posCnt + 1'b1;
    nextOffset    = frameSync ? offsetIn : actOffset;
    nextMode      = frameSync ? modeIn : actMode;
    armed         = synced | frameSync;
    cmdOut.halt   = ~groupEn;
    cmdOut.launch = groupEn & armed & (nextPos == nextOffset);
    cmdOut.width  = nextMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt    <= '0;
      actOffset <= '0;
      actMode   <= WIDTH_ONE;
      synced    <= 1'b0;
    end else begin
      posCnt <= nextPos;
      if (frameSync) begin
        actOffset <= offsetIn;
        actMode   <= modeIn;
      end
      synced <= groupEn & armed;
    end
  end

  // R6: settings only move on a sync
  a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameSync |=> ($stable(actOffset) && $stable(actMode)));

  // R2: a launch lands on the active offset position
  a_r2_launch_at_offset: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut.launch |=> (posCnt == actOffset));

  // R7: disabling drops the armed state
  a_r7_disarm: assert property (@(posedge clk) disable iff (!rstN)
    !groupEn |=> !synced);

endmodule

// File: rtl/frame_pulse_datapath.sv
module frame_pulse_datapath
  import seq_frame_pkg::*;
#(
  parameter int LINES = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCmd_t          cmdIn,
  output logic [LINES-1:0] pulseOut
);

  localparam int IDX_W = $clog2(LINES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  logic              busy;
  logic [IDX_W-1:0]  lineIdx;
  logic [WCNT_W-1:0] widthCnt;
  pulseWidth_e       widthSel;
  logic              pulseEnd;

  assign pulseEnd = (widthCnt == widthLast(widthSel));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      lineIdx  <= '0;
      widthCnt <= '0;
      widthSel <= WIDTH_ONE;
    end else if (cmdIn.halt) begin
      busy     <= 1'b0;
      lineIdx  <= '0;
      widthCnt <= '0;
    end else if (cmdIn.launch) begin
      busy     <= 1'b1;
      lineIdx  <= '0;
      widthCnt <= '0;
      widthSel <= cmdIn.width;
    end else if (busy) begin
      if (pulseEnd) begin
        widthCnt <= '0;
        if (lineIdx == LAST_IDX) begin
          busy    <= 1'b0;
          lineIdx <= '0;
        end else begin
          lineIdx <= lineIdx + 1'b1;
        end
      end else begin
        widthCnt <= widthCnt + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign pulseOut[i] = busy && (lineIdx == IDX_W'(i));
  end

  // R4: never two lines at once
  a_r4_one_line: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulseOut));

  // R4: lines advance strictly by one
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(cmdIn.launch) && (lineIdx != $past(lineIdx)))
      |-> (lineIdx == $past(lineIdx) + 1'b1));

  // R3: counter stays within the selected width
  a_r3_width_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (widthCnt <= widthLast(widthSel)));

  // R3: a line holds until its width is spent
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmdIn.launch && !cmdIn.halt && !pulseEnd) |=> $stable(lineIdx));

  // R7: halt clears outputs next cycle
  a_r7_halt_clears: assert property (@(posedge clk) disable iff (!rstN)
    cmdIn.halt |=> (pulseOut == '0));

endmodule

// File: rtl/seq_frame_pulser.sv
module seq_frame_pulser
  import seq_frame_pkg::*;
#(
  parameter int GROUPS     = 2,
  parameter int LINES      = 12,
  parameter int FRAME_BITS = 1024,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      frameSync,
  input  logic [GROUPS-1:0]         groupEn,
  input  logic [2*GROUPS-1:0]       widthMode,
  input  logic [POS_W*GROUPS-1:0]   startOffset,
  output logic [LINES*GROUPS-1:0]   pulses
);

  seqCmd_t grpCmd [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    frame_pulse_ctrl #(
      .FRAME_BITS (FRAME_BITS),
      .POS_W      (POS_W)
    ) i_ctrl (
      .clk       (clk),
      .rstN      (rstN),
      .frameSync (frameSync),
      .groupEn   (groupEn[g]),
      .modeIn    (pulseWidth_e'(widthMode[2*g +: 2])),
      .offsetIn  (startOffset[POS_W*g +: POS_W]),
      .cmdOut    (grpCmd[g])
    );

    frame_pulse_datapath #(
      .LINES (LINES)
    ) i_datapath (
      .clk      (clk),
      .rstN     (rstN),
      .cmdIn    (grpCmd[g]),
      .pulseOut (pulses[LINES*g +: LINES])
    );
  end

endmodule

// File: tb/test_seq_frame_pulser.sv
module test_seq_frame_pulser;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 1024;
  localparam int NG         = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameSync;
  logic [1:0]  groupEn;
  logic [3:0]  widthMode;
  logic [19:0] startOffset;
  logic [23:0] pulses;

  int errors = 0;
  int checks = 0;
  bit chkOn  = 1'b0;
  string curTag = "R1";

  seq_frame_pulser i_seq_frame_pulser (
    .clk         (clk),
    .rstN        (rstN),
    .frameSync   (frameSync),
    .groupEn     (groupEn),
    .widthMode   (widthMode),
    .startOffset (startOffset),
    .pulses      (pulses)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int widthBits(logic [1:0] m);
    case (m)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [11:0] expVec(bit run, int el, int w);
    logic [11:0] r = '0;
    if (run && (el / w) < 12) r[el / w] = 1'b1;
    return r;
  endfunction

  // Reference model, built from the requirements (elapsed-time formulation)
  int         mPos [NG];
  int         mOff [NG];
  logic [1:0] mMode [NG];
  bit         mSynced [NG];
  bit         mRun [NG];
  int         mEl [NG];
  int         mW [NG];

  always @(posedge clk) begin
    for (int g = 0; g < NG; g++) begin
      int np;
      int noff;
      logic [1:0] nm;
      bit armed;
      if (!rstN) begin
        mPos[g] <= 0; mOff[g] <= 0; mMode[g] <= 2'b00;
        mSynced[g] <= 1'b0; mRun[g] <= 1'b0; mEl[g] <= 0; mW[g] <= 1;
      end else begin
        np   = frameSync ? 0 : ((mPos[g] == FRAME-1) ? 0 : mPos[g] + 1);
        noff = frameSync ? int'(startOffset[g*10 +: 10]) : mOff[g];
        nm   = frameSync ? widthMode[g*2 +: 2] : mMode[g];
        mPos[g] <= np;
        if (frameSync) begin
          mOff[g]  <= noff;
          mMode[g] <= nm;
        end
        armed = mSynced[g] || frameSync;
        if (!groupEn[g]) begin          // R7
          mSynced[g] <= 1'b0;
          mRun[g]    <= 1'b0;
        end else begin
          mSynced[g] <= armed;
          if (armed && np == noff) begin // R2, R9
            mRun[g] <= 1'b1;
            mEl[g]  <= 0;
            mW[g]   <= widthBits(nm);    // R3
          end else if (mRun[g]) begin    // R4, R5
            mEl[g] <= mEl[g] + 1;
            if (mEl[g] + 1 >= 12 * mW[g]) mRun[g] <= 1'b0;
          end
        end
      end
    end
  end

  task automatic check(bit ok, string tag, logic [11:0] got, logic [11:0] exp, int g);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s group %0d at %0t: got %b expected %b", tag, g, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      for (int g = 0; g < NG; g++) begin
        logic [11:0] got;
        logic [11:0] exp;
        got = pulses[g*12 +: 12];
        exp = rstN ? expVec(mRun[g], mEl[g], mW[g]) : 12'h000;
        check(got === exp, curTag, got, exp, g);
      end
    end
  end

  task automatic randCfg();
    widthMode   = 4'($urandom);
    startOffset = 20'($urandom);
  endtask

  // action: 0 none, 1 new random settings, 2 disable group 0, 3 enable group 0
  task automatic runFrame(int actAt, int action);
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk);
      frameSync = (c == 0);
      if (c == actAt) begin
        case (action)
          1: randCfg();
          2: groupEn[0] = 1'b0;
          3: groupEn[0] = 1'b1;
          default: ;
        endcase
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; frameSync = 1'b0; groupEn = 2'b11;
    widthMode = '0; startOffset = '0;
    // R1: reset and pre-sync state
    curTag = "R1";
    chkOn = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (20) @(negedge clk);

    // R2: offset 0 and 37, narrow widths
    curTag = "R2";
    widthMode = {2'b01, 2'b00};
    startOffset = {10'd37, 10'd0};
    runFrame(-1, 0);
    startOffset = {10'd1023, 10'd512};
    runFrame(-1, 0);

    // R3: every width code on both groups
    curTag = "R3";
    for (int m = 0; m < 4; m++) begin
      widthMode = {2'(m), 2'(3 - m)};
      startOffset = {10'd100, 10'd3};
      runFrame(-1, 0);
    end

    // R5: sequences running past the frame end, R9: restart mid-sequence
    curTag = "R5";
    widthMode = 4'b1111;
    startOffset = {10'd1000, 10'd1020};
    runFrame(-1, 0);
    runFrame(-1, 0);
    curTag = "R9";
    startOffset = {10'd60, 10'd5};
    runFrame(-1, 0);
    runFrame(-1, 0);

    // R6: settings rewritten mid-frame only apply at the next sync
    curTag = "R6";
    widthMode = 4'b1010;
    startOffset = {10'd20, 10'd10};
    runFrame(15, 1);
    runFrame(300, 1);

    // R7: disable mid-sequence, re-enable mid-frame
    curTag = "R7";
    widthMode = 4'b1111;
    startOffset = {10'd30, 10'd40};
    runFrame(90, 2);
    startOffset = {10'd30, 10'd500};
    runFrame(10, 3);
    runFrame(-1, 0);

    // R8: group 1 off while group 0 keeps running
    curTag = "R8";
    groupEn = 2'b01;
    runFrame(200, 1);
    groupEn = 2'b10;
    runFrame(200, 1);
    groupEn = 2'b11;

    // R4: random settings and mid-frame changes
    curTag = "R4";
    for (int f = 0; f < 8; f++) begin
      randCfg();
      runFrame(int'($urandom_range(0, FRAME-1)), int'($urandom_range(0, 1)));
    end

    chkOn = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule